// File: doc/BRIEF.md
# Byte/Word I/O Port Access Unit

This block sits between a processor's port input/output instructions and an I/O port bus on which every port is 8 bits wide. A request names a port either through an 8-bit immediate, which reaches only the lowest 256 ports, or through a 16-bit register, which reaches all 65536. The request also gives a width of one byte or one word, a direction, and the accumulator value to be written. The block runs one or two bus cycles and returns the read result in accumulator form: a full word, or a byte in the low half with the upper half zero.

Two neighbouring byte ports can be reached together as one word port. A word at an even address goes out as a single bus cycle with both byte lanes enabled. A word at an odd address becomes two byte cycles: first the low byte at the addressed port, then the high byte at the next address, wrapping from FFFFh to 0000h. Every bus cycle keeps its address, lanes, write data and strobe steady until the port bus signals ready. A one-cycle done pulse closes the transfer. Any transfer that touches ports 00F8h to 00FFh raises a reserved flag, which the caller can use to trap the access.

Top module: `ioport_xfer_unit`

## Requirements
- R1: After reset the unit is idle: busy, both strobes, done, the byte enables and the reserved flag are all 0.
- R2: When `req_indirect` is 0, the port address is the 8-bit immediate zero-extended to 16 bits, and `req_reg` has no effect.
- R3: When `req_indirect` is 1, the port address is the full 16-bit `req_reg`.
- R4: A word transfer at an even address runs as one bus cycle with `pb_be`=11. A write drives the whole accumulator on `pb_wdata`, and a read returns the whole of `pb_rdata`.
- R5: A byte transfer runs as one bus cycle. `pb_be` is 01 (lane bits 7:0) at an even address and 10 (lane bits 15:8) at an odd address. A write places the accumulator low byte on the enabled lane. A read returns the enabled lane in `rd_data[7:0]` with `rd_data[15:8]`=0.
- R6: A word transfer at an odd address A runs as two cycles. The first is at A with `pb_be`=10, carrying the accumulator low byte. The second is at A+1 (mod 65536) with `pb_be`=01, carrying the high byte. A read assembles `{second lane, first lane}`.
- R7: While a strobe is high and `pb_ready` is low, the address, byte enables, write data and strobe stay unchanged on the next cycle.
- R8: `busy` is high from the cycle after a request is accepted until the final ready is seen. `done` is a single-cycle pulse in the cycle after the final ready, and `rd_data` is valid then.
- R9: `rsv_flag` is set when any byte port touched by the transfer lies in 00F8h to 00FFh. It is cleared when a transfer touches none. It is updated only when a request is accepted and holds until the next one.
- R10: A request presented while busy is ignored: it causes no extra bus cycle and does not change the transfer in progress.
- R11: At most one of `pb_rd` and `pb_wr` is high, and every strobed cycle has a nonzero byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_indirect | input | 1 | 1: address from register, 0: from immediate |
| req_imm | input | 8 | Immediate port number |
| req_reg | input | 16 | Register port number |
| req_word | input | 1 | 1: 16-bit transfer, 0: 8-bit |
| req_write | input | 1 | 1: output to port, 0: input from port |
| req_wdata | input | 16 | Accumulator value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result in accumulator form |
| rsv_flag | output | 1 | Last accepted transfer touched the reserved range |
| pb_addr | output | 16 | Port bus byte address |
| pb_be | output | 2 | Port bus lane enables |
| pb_rd | output | 1 | Port bus read strobe |
| pb_wr | output | 1 | Port bus write strobe |
| pb_wdata | output | 16 | Port bus write data |
| pb_ready | input | 1 | Port bus cycle complete |
| pb_rdata | input | 16 | Port bus read data (even port on bits 7:0) |

## Verification
A wrong split decision appears on the first bus cycle of a transfer. It shows as the wrong lane enable, or as a second strobed cycle that should not exist or that is missing, and the bench's per-cycle log of address, lanes and data catches it. A bad held byte or a bad lane-assembly state is only visible in the write data of the second cycle, or in `rd_data` at the done pulse, up to two bus cycles after the request. Reserved decoding errors show on `rsv_flag` one cycle after acceptance. A phase register that does not return to idle leaves `busy` high and produces no done pulse.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

    localparam int PORT_AW = 16;
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } xfer_st_e;

    typedef struct packed {
        xfer_st_e             st;
        logic [PORT_AW-1:0]   addr;
        logic [LANES-1:0]     be;
        logic                 wr;
        logic [DATA_W-1:0]    wdata;
        logic [7:0]           hi_byte;
        logic                 split_pend;
        logic                 phase2;
        logic [DATA_W-1:0]    res;
        logic                 done;
        logic                 rsv;
    } xfer_state_t;

endpackage

// File: rtl/ioport_addr_sel.sv
module ioport_addr_sel #(
    parameter int AW   = 16,
    parameter int IMMW = 8
) (
    input  logic          indirect,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0] rg,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - IMMW;

    assign addr = indirect ? rg : {{PADW{1'b0}}, imm};
endmodule

// File: rtl/ioport_lane_plan.sv
module ioport_lane_plan #(
    parameter int          AW     = 16,
    parameter logic [15:0] RSV_LO = 16'h00F8,
    parameter logic [15:0] RSV_HI = 16'h00FF
) (
    input  logic [AW-1:0] addr,
    input  logic          word,
    output logic [1:0]    be_first,
    output logic          split,
    output logic          rsv_hit
);
    localparam int TOUCH = 2;

    logic          odd;
    logic [TOUCH-1:0] hit;

    assign odd = addr[0];

    always_comb begin
        if (word && !odd) be_first = 2'b11;
        else if (odd)     be_first = 2'b10;
        else              be_first = 2'b01;
    end

    assign split = word && odd;

    for (genvar g = 0; g < TOUCH; g++) begin : g_touch
        logic [AW-1:0] b_addr;
        assign b_addr = addr + AW'(g);
        assign hit[g] = ((g == 0) || word) &&
                        (b_addr >= AW'(RSV_LO)) && (b_addr <= AW'(RSV_HI));
    end

    assign rsv_hit = |hit;
endmodule

// File: rtl/ioport_xfer_unit.sv
module ioport_xfer_unit
    import ioport_pkg::*;
#(
    parameter int          AW     = PORT_AW,
    parameter int          DW     = DATA_W,
    parameter int          IMMW   = 8,
    parameter logic [15:0] RSV_LO = 16'h00F8,
    parameter logic [15:0] RSV_HI = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_indirect,
    input  logic [IMMW-1:0] req_imm,
    input  logic [AW-1:0] req_reg,
    input  logic          req_word,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          rsv_flag,
    output logic [AW-1:0] pb_addr,
    output logic [1:0]    pb_be,
    output logic          pb_rd,
    output logic          pb_wr,
    output logic [DW-1:0] pb_wdata,
    input  logic          pb_ready,
    input  logic [DW-1:0] pb_rdata
);
    localparam int LW = DW / 2;

    xfer_state_t q, d;

    logic [AW-1:0] sel_addr;
    logic [1:0]    be_first;
    logic          split;
    logic          rsv_hit;
    logic [LW-1:0] lane;

    ioport_addr_sel #(.AW(AW), .IMMW(IMMW)) u_addr (
        .indirect (req_indirect),
        .imm      (req_imm),
        .rg       (req_reg),
        .addr     (sel_addr)
    );

    ioport_lane_plan #(.AW(AW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_plan (
        .addr     (sel_addr),
        .word     (req_word),
        .be_first (be_first),
        .split    (split),
        .rsv_hit  (rsv_hit)
    );

    // lane that carries the enabled byte of a single-lane cycle
    assign lane = q.be[1] ? pb_rdata[DW-1:LW] : pb_rdata[LW-1:0];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st         = ST_BUS;
                    d.addr       = sel_addr;
                    d.be         = be_first;
                    d.wr         = req_write;
                    d.wdata      = (be_first == 2'b11) ? req_wdata
                                                       : {2{req_wdata[LW-1:0]}};
                    d.hi_byte    = req_wdata[DW-1:LW];
                    d.split_pend = split;
                    d.phase2     = 1'b0;
                    d.rsv        = rsv_hit;
                end
            end
            default: begin
                if (pb_ready) begin
                    if (!q.wr) begin
                        if (q.be == 2'b11) d.res = pb_rdata;
                        else if (q.phase2) d.res[DW-1:LW] = lane;
                        else               d.res = {{LW{1'b0}}, lane};
                    end
                    if (q.split_pend) begin
                        d.addr       = q.addr + AW'(1);
                        d.be         = 2'b01;
                        d.wdata      = {2{q.hi_byte}};
                        d.split_pend = 1'b0;
                        d.phase2     = 1'b1;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st == ST_BUS);
    assign done     = q.done;
    assign rd_data  = q.res;
    assign rsv_flag = q.rsv;
    assign pb_addr  = q.addr;
    assign pb_be    = busy ? q.be : 2'b00;
    assign pb_rd    = busy && !q.wr;
    assign pb_wr    = busy && q.wr;
    assign pb_wdata = q.wdata;
endmodule

// File: rtl/ioport_xfer_chk.sv
module ioport_xfer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        rsv_flag,
    input logic [15:0] pb_addr,
    input logic [1:0]  pb_be,
    input logic        pb_rd,
    input logic        pb_wr,
    input logic [15:0] pb_wdata,
    input logic        pb_ready
);
    logic strobe;
    assign strobe = pb_rd || pb_wr;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!strobe && pb_be == 2'b00)); // R1

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !pb_ready) |=> (strobe && $stable(pb_addr) && $stable(pb_be)
                                   && $stable(pb_wdata) && $stable(pb_rd))); // R7

    AST_SPLIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && pb_ready && pb_be == 2'b10) |=>
            (done || (strobe && pb_be == 2'b01 && pb_addr == $past(pb_addr) + 16'd1))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(strobe) && $past(pb_ready))); // R8

    AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rsv_flag)); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pb_rd, pb_wr}) && (!strobe || pb_be != 2'b00)); // R11
endmodule

bind ioport_xfer_unit ioport_xfer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rsv_flag (rsv_flag),
    .pb_addr  (pb_addr),
    .pb_be    (pb_be),
    .pb_rd    (pb_rd),
    .pb_wr    (pb_wr),
    .pb_wdata (pb_wdata),
    .pb_ready (pb_ready)
);

// File: tb/ioport_xfer_unit_tb.sv
module ioport_xfer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_indirect = 1'b0, req_word = 1'b0, req_write = 1'b0;
    logic [7:0]  req_imm = '0;
    logic [15:0] req_reg = '0, req_wdata = '0;
    logic        busy, done, rsv_flag, pb_rd, pb_wr;
    logic [15:0] rd_data, pb_addr, pb_wdata;
    logic [1:0]  pb_be;
    logic        pb_ready = 1'b0;
    logic [15:0] pb_rdata = '0;

    int nchk = 0, nbad = 0, ws = 0, wcnt = 0, lg_n = 0;
    logic [15:0] lg_addr [0:7];
    logic [1:0]  lg_be   [0:7];
    logic [15:0] lg_wd   [0:7];
    logic        lg_wr   [0:7];
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    ioport_xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indirect(req_indirect),
        .req_imm(req_imm), .req_reg(req_reg), .req_word(req_word), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .rsv_flag(rsv_flag), .pb_addr(pb_addr), .pb_be(pb_be), .pb_rd(pb_rd),
        .pb_wr(pb_wr), .pb_wdata(pb_wdata), .pb_ready(pb_ready), .pb_rdata(pb_rdata)
    );

    function automatic logic [7:0] pval(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // port device model: even port on bits 7:0, odd port on bits 15:8
    always @(negedge clk) begin
        pb_rdata = {pval({pb_addr[15:1], 1'b1}), pval({pb_addr[15:1], 1'b0})};
        if (pb_rd || pb_wr) begin
            if (wcnt >= ws) begin
                pb_ready = 1'b1;
                wcnt = 0;
                if (lg_n < 8) begin
                    lg_addr[lg_n] = pb_addr; lg_be[lg_n] = pb_be;
                    lg_wd[lg_n] = pb_wdata;  lg_wr[lg_n] = pb_wr;
                end
                lg_n++;
            end else begin
                pb_ready = 1'b0;
                wcnt++;
            end
        end else begin
            pb_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic ind, input logic [7:0] imm, input logic [15:0] rg,
                        input logic word, input logic wr, input logic [15:0] acc,
                        input logic poke);
        int t;
        @(negedge clk);
        lg_n = 0;
        req_indirect = ind; req_imm = imm; req_reg = rg;
        req_word = word; req_write = wr; req_wdata = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", busy, 1);
        if (poke) begin
            req_indirect = 1'b1; req_reg = 16'h0F00; req_word = 1'b0;
            req_write = ~wr; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R8 done seen", done, 1);
        chk("R8 busy low at done", busy, 0);
    endtask

    task automatic after_done;
        @(negedge clk);
        chk("R8 done single cycle", done, 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {pb_rd, pb_wr}, 0);
        chk("R1 done", done, 0);
        chk("R1 rsv", rsv_flag, 0);
        chk("R1 be", pb_be, 0);
    endtask

    task automatic t_direct_byte_read;
        ws = 0;
        xfer(1'b0, 8'h34, 16'hFFFF, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R2 cycles", lg_n, 1);
        chk("R2 addr", lg_addr[0], 16'h0034);
        chk("R5 be even", lg_be[0], 2'b01);
        chk("R5 read even lane", rd_data, {8'h00, pval(16'h0034)});
        chk("R11 rd strobe", lg_wr[0], 0);
        after_done();
    endtask

    task automatic t_direct_odd_byte_read;
        ws = 1;
        xfer(1'b0, 8'h81, 16'h1234, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R2 addr odd", lg_addr[0], 16'h0081);
        chk("R5 be odd", lg_be[0], 2'b10);
        chk("R5 read odd lane", rd_data, {8'h00, pval(16'h0081)});
        after_done();
    endtask

    task automatic t_indirect_odd_byte_write;
        ws = 0;
        xfer(1'b1, 8'h00, 16'h1235, 1'b0, 1'b1, 16'hABCD, 1'b0);
        chk("R3 cycles", lg_n, 1);
        chk("R3 addr", lg_addr[0], 16'h1235);
        chk("R5 be", lg_be[0], 2'b10);
        chk("R5 wdata lane", lg_wd[0][15:8], 8'hCD);
        chk("R11 wr strobe", lg_wr[0], 1);
        after_done();
    endtask

    task automatic t_aligned_word;
        ws = 2;
        xfer(1'b1, 8'h00, 16'h2000, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R4 read cycles", lg_n, 1);
        chk("R4 read be", lg_be[0], 2'b11);
        chk("R4 read data", rd_data, {pval(16'h2001), pval(16'h2000)});
        after_done();
        ws = 0;
        xfer(1'b1, 8'h00, 16'h3A10, 1'b1, 1'b1, 16'h5AA5, 1'b0);
        chk("R4 write cycles", lg_n, 1);
        chk("R4 write addr", lg_addr[0], 16'h3A10);
        chk("R4 write be", lg_be[0], 2'b11);
        chk("R4 write data", lg_wd[0], 16'h5AA5);
        after_done();
    endtask

    task automatic t_split_write;
        ws = 1;
        xfer(1'b1, 8'h00, 16'h0457, 1'b1, 1'b1, 16'h9A3C, 1'b0);
        chk("R6 cycles", lg_n, 2);
        chk("R6 addr1", lg_addr[0], 16'h0457);
        chk("R6 be1", lg_be[0], 2'b10);
        chk("R6 data1", lg_wd[0][15:8], 8'h3C);
        chk("R6 addr2", lg_addr[1], 16'h0458);
        chk("R6 be2", lg_be[1], 2'b01);
        chk("R6 data2", lg_wd[1][7:0], 8'h9A);
        after_done();
    endtask

    task automatic t_split_read_wrap;
        ws = 0;
        xfer(1'b1, 8'h00, 16'hFFFF, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R6 wrap cycles", lg_n, 2);
        chk("R6 wrap addr2", lg_addr[1], 16'h0000);
        chk("R6 read assemble", rd_data, {pval(16'h0000), pval(16'hFFFF)});
        after_done();
    endtask

    task automatic t_reserved;
        ws = 0;
        xfer(1'b0, 8'hF8, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R9 byte F8", rsv_flag, 1);
        after_done();
        chk("R9 held after done", rsv_flag, 1);
        xfer(1'b1, 8'h00, 16'h00F6, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R9 word F6 clear", rsv_flag, 0);
        xfer(1'b1, 8'h00, 16'h00F7, 1'b1, 1'b1, 16'h1111, 1'b0);
        chk("R9 word F7 straddle", rsv_flag, 1);
        xfer(1'b1, 8'h00, 16'h0100, 1'b1, 1'b0, 16'h0, 1'b0);
        chk("R9 word 0100 clear", rsv_flag, 0);
        xfer(1'b1, 8'h00, 16'h00FF, 1'b0, 1'b1, 16'h2222, 1'b0);
        chk("R9 byte FF", rsv_flag, 1);
        xfer(1'b1, 8'h00, 16'h01F8, 1'b0, 1'b0, 16'h0, 1'b0);
        chk("R9 byte 01F8 clear", rsv_flag, 0);
        after_done();
    endtask

    task automatic t_ignore_busy;
        ws = 2;
        xfer(1'b1, 8'h00, 16'h0563, 1'b1, 1'b1, 16'hC3E1, 1'b1);
        chk("R10 cycles", lg_n, 2);
        chk("R10 addr1", lg_addr[0], 16'h0563);
        chk("R10 addr2", lg_addr[1], 16'h0564);
        chk("R10 data2", lg_wd[1][7:0], 8'hC3);
        chk("R10 stayed write", lg_wr[1], 1);
        repeat (5) @(negedge clk);
        chk("R10 no extra cycle", lg_n, 2);
        chk("R10 idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_byte_read();
        t_direct_odd_byte_read();
        t_indirect_odd_byte_write();
        t_aligned_word();
        t_split_write();
        t_split_read_wrap();
        t_reserved();
        t_ignore_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nbad++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule